// File: doc/BRIEF.md
# Sequenced System Reset Generator

This block turns a handful of loosely timed reset sources into a clean, ordered set of resets for everything running on the slowest synchronous clock of a system. Three asynchronous requests feed it: a board-level pin, an internal auxiliary source and a debug-module request. A clock-lock indicator feeds it as well. Each request is synchronized and must stay active for a configured number of consecutive clocks before it counts. The request must then stay inactive for the same number of clocks before it lets go.

Any qualified request, a lost lock, or power-up drives every reset output active on one clock edge. Release is staged in three steps. Bus and interconnect resets clear first. Peripheral resets clear 16 clocks later, and the processor reset clears 16 clocks after that. A new request during the staged release reasserts everything at once. Each output class is replicated as a vector in which every copy has its own flip-flop, so the copies can be spread across the die to share out the load.

Top module: `sysrst_seq`

## Requirements
- R1: From power-up every output is asserted, starting no later than the first rising edge. With the default counts of 16, bus and interconnect resets deassert at the 16th edge, peripheral resets at the 32nd edge and the processor reset at the 48th edge.
- R2: The external request is active at the level chosen by EXT_ACTIVE_HIGH, which defaults to 0 (active low). Holding the pin at its inactive level has no effect on any output.
- R3: The auxiliary request is active at the level chosen by AUX_ACTIVE_HIGH, which defaults to 1 (active high). It is qualified against AUX_WIDTH, which defaults to 3.
- R4: The debug request is always active high. It is qualified against EXT_WIDTH, which defaults to 5, regardless of the external polarity setting.
- R5: A request that stays active for fewer consecutive clocks than its width has no effect. A one-clock gap restarts the count, so two short pulses do not add together.
- R6: When a request goes active just before rising edge 1 and stays active for W clocks, all outputs assert together at edge W+2.
- R7: When a held request goes inactive just before edge 1, bus and interconnect resets deassert at edge W+2. Peripheral resets deassert 16 edges later, and the processor reset deasserts 16 edges after that.
- R8: A request that qualifies while the staged release is running reasserts every output on the same edge.
- R9: When clk_locked drops just before edge 1, all outputs assert at edge 3. When it returns high just before edge 1, the staged release begins at edge 3.
- R10: All copies within a class always carry the same value. Each interconnect copy is the complement of the bus reset, and each active-low peripheral copy is the complement of the active-high peripheral reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slowest synchronous system clock |
| ext_rst_req | input | 1 | External reset request, asynchronous, polarity set by EXT_ACTIVE_HIGH |
| aux_rst_req | input | 1 | Auxiliary reset request, asynchronous, polarity set by AUX_ACTIVE_HIGH |
| dbg_rst_req | input | 1 | Debug reset request, asynchronous, active high |
| clk_locked | input | 1 | Clock-lock indicator; low forces reset |
| cpu_rst | output | 1 | Processor reset, active high, released last |
| bus_rst | output | BUS_COPIES | Bus-structure resets, active high, released first |
| icn_rst_n | output | ICN_COPIES | Interconnect resets, active low, released first |
| periph_rst | output | PERIPH_COPIES | Peripheral resets, active high, released second |
| periph_rst_n | output | PERIPH_N_COPIES | Peripheral resets, active low, released second |

## Verification
A counter or qualification flag that is off by one shows up within W+2 edges of the input change: the outputs assert or release one edge early or late, or a pulse of W-1 clocks gets through. A sequencer that skips, repeats or stalls a stage shows up within 16 edges, because the gap between one class releasing and the next is then wrong. A missed abort in the release path shows up at the edge where the outputs should reassert. A bad copy in the replicated banks shows up on the very next edge as a mismatch between copies or between the two polarities.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [2:0] {
    ST_POR        = 3'd0,
    ST_HOLD       = 3'd1,
    ST_REL_BUS    = 3'd2,
    ST_REL_PERIPH = 3'd3,
    ST_RUN        = 3'd4
  } seq_state_t;

  // bits needed for a counter that reaches n-1
  function automatic int unsigned cnt_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // release decode per output class
  function automatic logic bus_free(seq_state_t s);
    return (s == ST_REL_BUS) || (s == ST_REL_PERIPH) || (s == ST_RUN);
  endfunction

  function automatic logic periph_free(seq_state_t s);
    return (s == ST_REL_PERIPH) || (s == ST_RUN);
  endfunction

  function automatic logic cpu_free(seq_state_t s);
    return (s == ST_RUN);
  endfunction

endpackage

// File: rtl/srg_req_filter.sv
module srg_req_filter #(
  parameter bit          ACTIVE_HIGH = 1'b1,
  parameter int unsigned WIDTH       = 4
) (
  input  logic clk,
  input  logic raw,
  output logic req
);
  localparam int unsigned CW = srg_pkg::cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [1:0]    sync = 2'b00;
  logic [CW-1:0] act_cnt = '0;
  logic [CW-1:0] idle_cnt = '0;
  logic          held = 1'b0;
  logic          lvl;
  logic          hit_on;
  logic          hit_off;

  // normalise to active-high before the synchronizer
  always_ff @(posedge clk) begin
    sync <= {sync[0], (raw == ACTIVE_HIGH)};
  end

  assign lvl     = sync[1];
  assign hit_on  = lvl && (act_cnt == LAST);
  assign hit_off = !lvl && (idle_cnt == LAST);

  always_ff @(posedge clk) begin
    act_cnt  <= lvl ? ((act_cnt == LAST) ? LAST : act_cnt + 1'b1) : '0;
    idle_cnt <= lvl ? '0 : ((idle_cnt == LAST) ? LAST : idle_cnt + 1'b1);
    held     <= held ? !hit_off : hit_on;
  end

  assign req = held ? !hit_off : hit_on;

endmodule

// File: rtl/srg_seq.sv
module srg_seq
  import srg_pkg::*;
#(
  parameter int unsigned POR_CYCLES   = 16,
  parameter int unsigned STAGE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       hold_req,
  output seq_state_t state_o,
  output seq_state_t next_o
);
  localparam int unsigned CW = cnt_bits(max_u(POR_CYCLES, STAGE_CYCLES));
  localparam logic [CW-1:0] POR_LAST   = CW'(POR_CYCLES - 1);
  localparam logic [CW-1:0] STAGE_LAST = CW'(STAGE_CYCLES - 1);

  seq_state_t    state = ST_POR;
  logic [CW-1:0] cnt = '0;
  seq_state_t    nxt;
  logic [CW-1:0] ncnt;

  always_comb begin
    nxt  = state;
    ncnt = '0;
    if (hold_req) begin
      nxt = ST_HOLD;
    end else begin
      case (state)
        ST_POR: begin
          if (cnt == POR_LAST) nxt = ST_REL_BUS;
          else ncnt = cnt + 1'b1;
        end
        ST_HOLD: nxt = ST_REL_BUS;
        ST_REL_BUS: begin
          if (cnt == STAGE_LAST) nxt = ST_REL_PERIPH;
          else ncnt = cnt + 1'b1;
        end
        ST_REL_PERIPH: begin
          if (cnt == STAGE_LAST) nxt = ST_RUN;
          else ncnt = cnt + 1'b1;
        end
        ST_RUN:  nxt = ST_RUN;
        default: nxt = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state <= nxt;
    cnt   <= ncnt;
  end

  assign state_o = state;
  assign next_o  = nxt;

endmodule

// File: rtl/srg_out_bank.sv
module srg_out_bank #(
  parameter int unsigned COPIES     = 1,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              release_i,
  output logic [COPIES-1:0] rst_o
);
  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    logic q = ACTIVE_LOW ? 1'b0 : 1'b1;
    always_ff @(posedge clk) begin
      q <= ACTIVE_LOW ? release_i : !release_i;
    end
    assign rst_o[i] = q;
  end

endmodule

// File: rtl/sysrst_seq.sv
module sysrst_seq
  import srg_pkg::*;
#(
  parameter bit          EXT_ACTIVE_HIGH = 1'b0,
  parameter bit          AUX_ACTIVE_HIGH = 1'b1,
  parameter int unsigned EXT_WIDTH       = 5,
  parameter int unsigned AUX_WIDTH       = 3,
  parameter int unsigned BUS_COPIES      = 2,
  parameter int unsigned ICN_COPIES      = 3,
  parameter int unsigned PERIPH_COPIES   = 4,
  parameter int unsigned PERIPH_N_COPIES = 2,
  parameter int unsigned POR_CYCLES      = 16,
  parameter int unsigned STAGE_CYCLES    = 16
) (
  input  logic                       clk,
  input  logic                       ext_rst_req,
  input  logic                       aux_rst_req,
  input  logic                       dbg_rst_req,
  input  logic                       clk_locked,
  output logic                       cpu_rst,
  output logic [BUS_COPIES-1:0]      bus_rst,
  output logic [ICN_COPIES-1:0]      icn_rst_n,
  output logic [PERIPH_COPIES-1:0]   periph_rst,
  output logic [PERIPH_N_COPIES-1:0] periph_rst_n
);
  localparam int unsigned NSRC = 3;
  localparam bit          SRC_POL [NSRC] = '{EXT_ACTIVE_HIGH, AUX_ACTIVE_HIGH, 1'b1};
  localparam int unsigned SRC_WID [NSRC] = '{EXT_WIDTH, AUX_WIDTH, EXT_WIDTH};

  logic [NSRC-1:0] src_raw;
  logic [NSRC-1:0] src_req;
  logic [1:0]      lock_sync = 2'b11;
  logic            lock_lost;
  logic            hold_req;
  seq_state_t      seq_state;
  seq_state_t      seq_next;
  logic [0:0]      cpu_vec;

  assign src_raw = {dbg_rst_req, aux_rst_req, ext_rst_req};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    srg_req_filter #(
      .ACTIVE_HIGH (SRC_POL[s]),
      .WIDTH       (SRC_WID[s])
    ) u_filt (
      .clk (clk),
      .raw (src_raw[s]),
      .req (src_req[s])
    );
  end

  always_ff @(posedge clk) begin
    lock_sync <= {lock_sync[0], clk_locked};
  end

  assign lock_lost = !lock_sync[1];
  assign hold_req  = lock_lost || (|src_req);

  srg_seq #(
    .POR_CYCLES   (POR_CYCLES),
    .STAGE_CYCLES (STAGE_CYCLES)
  ) u_seq (
    .clk      (clk),
    .hold_req (hold_req),
    .state_o  (seq_state),
    .next_o   (seq_next)
  );

  srg_out_bank #(.COPIES(BUS_COPIES), .ACTIVE_LOW(1'b0)) u_bus (
    .clk (clk), .release_i (bus_free(seq_next)), .rst_o (bus_rst)
  );

  srg_out_bank #(.COPIES(ICN_COPIES), .ACTIVE_LOW(1'b1)) u_icn (
    .clk (clk), .release_i (bus_free(seq_next)), .rst_o (icn_rst_n)
  );

  srg_out_bank #(.COPIES(PERIPH_COPIES), .ACTIVE_LOW(1'b0)) u_per (
    .clk (clk), .release_i (periph_free(seq_next)), .rst_o (periph_rst)
  );

  srg_out_bank #(.COPIES(PERIPH_N_COPIES), .ACTIVE_LOW(1'b1)) u_pern (
    .clk (clk), .release_i (periph_free(seq_next)), .rst_o (periph_rst_n)
  );

  srg_out_bank #(.COPIES(1), .ACTIVE_LOW(1'b0)) u_cpu (
    .clk (clk), .release_i (cpu_free(seq_next)), .rst_o (cpu_vec)
  );

  assign cpu_rst = cpu_vec[0];

endmodule

// File: rtl/sysrst_seq_chk.sv
module sysrst_seq_chk
  import srg_pkg::*;
#(
  parameter int unsigned BUS_COPIES      = 2,
  parameter int unsigned ICN_COPIES      = 3,
  parameter int unsigned PERIPH_COPIES   = 4,
  parameter int unsigned PERIPH_N_COPIES = 2
) (
  input logic                       clk,
  input logic                       hold_req,
  input logic                       lock_lost,
  input seq_state_t                 seq_state,
  input logic                       cpu_rst,
  input logic [BUS_COPIES-1:0]      bus_rst,
  input logic [ICN_COPIES-1:0]      icn_rst_n,
  input logic [PERIPH_COPIES-1:0]   periph_rst,
  input logic [PERIPH_N_COPIES-1:0] periph_rst_n
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  por_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (seq_state == ST_POR) |-> (cpu_rst && bus_rst[0] && periph_rst[0]));

  // R6
  qualified_assert_chk: assert property (@(posedge clk) disable iff (!armed)
    hold_req |=> (cpu_rst && bus_rst[0] && periph_rst[0] && !icn_rst_n[0]));

  // R9
  lock_loss_chk: assert property (@(posedge clk) disable iff (!armed)
    lock_lost |=> (cpu_rst && bus_rst[0]));

  // R7
  periph_after_bus_chk: assert property (@(posedge clk) disable iff (!armed)
    $fell(periph_rst[0]) |-> (!bus_rst[0] && $past(!bus_rst[0])));

  // R7
  cpu_after_periph_chk: assert property (@(posedge clk) disable iff (!armed)
    $fell(cpu_rst) |-> (!periph_rst[0] && $past(!periph_rst[0])));

  // R8
  together_chk: assert property (@(posedge clk) disable iff (!armed)
    $rose(bus_rst[0]) |-> (cpu_rst && periph_rst[0]));

  // R10
  copies_match_chk: assert property (@(posedge clk) disable iff (!armed)
    (bus_rst == {BUS_COPIES{bus_rst[0]}}) &&
    (icn_rst_n == {ICN_COPIES{!bus_rst[0]}}) &&
    (periph_rst == {PERIPH_COPIES{periph_rst[0]}}) &&
    (periph_rst_n == {PERIPH_N_COPIES{!periph_rst[0]}}));

endmodule

bind sysrst_seq sysrst_seq_chk #(
  .BUS_COPIES      (BUS_COPIES),
  .ICN_COPIES      (ICN_COPIES),
  .PERIPH_COPIES   (PERIPH_COPIES),
  .PERIPH_N_COPIES (PERIPH_N_COPIES)
) u_chk (
  .clk          (clk),
  .hold_req     (hold_req),
  .lock_lost    (lock_lost),
  .seq_state    (seq_state),
  .cpu_rst      (cpu_rst),
  .bus_rst      (bus_rst),
  .icn_rst_n    (icn_rst_n),
  .periph_rst   (periph_rst),
  .periph_rst_n (periph_rst_n)
);

// File: tb/sysrst_seq_test.sv
module sysrst_seq_test;
  localparam int EXT_W = 5;
  localparam int AUX_W = 3;
  localparam int NB = 2, NI = 3, NP = 4, NPN = 2;

  // vector: {src[3:0], expect[3:0], len[7:0]}; src 0=ext 1=aux 2=dbg
  localparam int NVEC = 7;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0004, 16'h0105, 16'h0109, 16'h1002, 16'h1103, 16'h2004, 16'h2105
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic ext_n = 1'b1;
  logic aux   = 1'b0;
  logic dbg   = 1'b0;
  logic lock  = 1'b1;
  logic           cpu_rst;
  logic [NB-1:0]  bus_rst;
  logic [NI-1:0]  icn_rst_n;
  logic [NP-1:0]  periph_rst;
  logic [NPN-1:0] periph_rst_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  sysrst_seq #(
    .EXT_ACTIVE_HIGH (1'b0), .AUX_ACTIVE_HIGH (1'b1),
    .EXT_WIDTH (EXT_W), .AUX_WIDTH (AUX_W),
    .BUS_COPIES (NB), .ICN_COPIES (NI),
    .PERIPH_COPIES (NP), .PERIPH_N_COPIES (NPN),
    .POR_CYCLES (16), .STAGE_CYCLES (16)
  ) uut (
    .clk (clk), .ext_rst_req (ext_n), .aux_rst_req (aux),
    .dbg_rst_req (dbg), .clk_locked (lock),
    .cpu_rst (cpu_rst), .bus_rst (bus_rst), .icn_rst_n (icn_rst_n),
    .periph_rst (periph_rst), .periph_rst_n (periph_rst_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // output snapshot: {cpu, bus all set, icn all clear, per all set, per_n all clear}
  function automatic int bus_on();
    return (bus_rst == '1 && icn_rst_n == '0) ? 1 : (bus_rst == '0 && icn_rst_n == '1) ? 0 : 2;
  endfunction
  function automatic int per_on();
    return (periph_rst == '1 && periph_rst_n == '0) ? 1 : (periph_rst == '0 && periph_rst_n == '1) ? 0 : 2;
  endfunction
  function automatic int all_on();
    return (cpu_rst && bus_on() == 1 && per_on() == 1) ? 1 : 0;
  endfunction
  function automatic int all_off();
    return (!cpu_rst && bus_on() == 0 && per_on() == 0) ? 1 : 0;
  endfunction

  task automatic drive(input int src, input bit act);
    case (src)
      0: ext_n = !act;
      1: aux   = act;
      default: dbg = act;
    endcase
  endtask

  // called right after the request is driven inactive
  task automatic release_seq(input int w, input string tag);
    step(w + 1);
    chk(bus_on() == 1, {tag, " bus held"}, bus_on(), 1);
    step(1);
    chk(bus_on() == 0 && per_on() == 1, {tag, " bus released first"}, bus_on(), 0);
    step(15);
    chk(per_on() == 1, {tag, " periph held 16"}, per_on(), 1);
    step(1);
    chk(per_on() == 0 && cpu_rst, {tag, " periph released"}, per_on(), 0);
    step(15);
    chk(cpu_rst == 1'b1, {tag, " cpu held 16"}, cpu_rst, 1);
    step(1);
    chk(all_off() == 1, {tag, " cpu released"}, all_off(), 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    // R1 power-up
    step(1);
    chk(all_on() == 1, "R1 all asserted at first edge", all_on(), 1);
    step(14);
    chk(bus_on() == 1, "R1 bus held to edge 15", bus_on(), 1);
    step(1);
    chk(bus_on() == 0, "R1 bus released edge 16", bus_on(), 0);
    step(15);
    chk(per_on() == 1, "R1 periph held edge 31", per_on(), 1);
    step(1);
    chk(per_on() == 0, "R1 periph released edge 32", per_on(), 0);
    step(15);
    chk(cpu_rst == 1'b1, "R1 cpu held edge 47", cpu_rst, 1);
    step(1);
    chk(all_off() == 1, "R1 cpu released edge 48", all_off(), 1);

    // R2 R3 idle at inactive levels
    step(20);
    chk(all_off() == 1, "R2 R3 inactive levels ignored", all_off(), 1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int src = int'(VEC[v][15:12]);
      int exp = int'(VEC[v][11:8]);
      int len = int'(VEC[v][7:0]);
      string tag = (exp == 0) ? "R5 short pulse" :
                   (src == 0) ? "R2 ext qualifies" :
                   (src == 1) ? "R3 aux qualifies" : "R4 dbg qualifies";
      seen = 1'b0;
      drive(src, 1'b1);
      for (int k = 0; k < len; k++) begin
        step(1);
        seen |= cpu_rst;
      end
      drive(src, 1'b0);
      for (int k = 0; k < 12; k++) begin
        step(1);
        seen |= cpu_rst;
      end
      chk(int'(seen) == exp, tag, int'(seen), exp);
      for (int k = 0; k < 80 && cpu_rst; k++) step(1);
      step(2);
    end

    // R6 latency and R7 release timing on the external pin
    ext_n = 1'b0;
    step(6);
    chk(all_off() == 1, "R6 not yet at edge W+1", all_off(), 1);
    step(1);
    chk(all_on() == 1, "R6 all asserted at edge W+2", all_on(), 1);
    step(5);
    ext_n = 1'b1;
    release_seq(EXT_W, "R7");

    // R5 interrupted pulses do not add up
    seen = 1'b0;
    ext_n = 1'b0; step(3); seen |= cpu_rst;
    ext_n = 1'b1; step(1); seen |= cpu_rst;
    ext_n = 1'b0; step(3); seen |= cpu_rst;
    ext_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step(1);
      seen |= cpu_rst;
    end
    chk(seen == 1'b0, "R5 gap restarts count", int'(seen), 0);

    // R8 abort during staged release
    aux = 1'b1; step(3); aux = 1'b0;
    step(AUX_W + 2);
    chk(bus_on() == 0 && per_on() == 1, "R8 in bus release stage", bus_on(), 0);
    step(4);
    aux = 1'b1;
    step(AUX_W + 1);
    chk(bus_on() == 0, "R8 bus still free before qualify", bus_on(), 0);
    step(1);
    chk(all_on() == 1, "R8 all reasserted together", all_on(), 1);
    aux = 1'b0;
    release_seq(AUX_W, "R8 after abort");

    // R9 lock loss and return
    lock = 1'b0;
    step(2);
    chk(all_off() == 1, "R9 no reset at edge 2", all_off(), 1);
    step(1);
    chk(all_on() == 1, "R9 reset at edge 3", all_on(), 1);
    step(10);
    lock = 1'b1;
    step(2);
    chk(bus_on() == 1, "R9 bus held at edge 2 after lock", bus_on(), 1);
    step(1);
    chk(bus_on() == 0, "R9 release begins edge 3", bus_on(), 0);
    step(32);
    chk(all_off() == 1, "R9 R10 fully released", all_off(), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule